// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

This block is an 8-bit timer with two compare channels, A and B. Each channel drives one output pin. A 3-bit waveform-mode field picks how the counter runs: free-running (normal), clear when it reaches compare register A (CTC), single-slope fast PWM, or dual-slope phase-correct PWM. Each channel's 2-bit output-mode field then decides what a compare match, the count direction and the TOP value do to its pin. An override flag tells the surrounding port logic when the pin value replaces ordinary port data. The block also gives an overflow strobe and one match strobe per channel.

The counter is built around a two-state direction machine. `ST_UP` is the reset state and the only state used outside phase-correct mode. Transition TURN_DOWN (`ST_UP` to `ST_DOWN`) fires when the count reaches or passes TOP in phase-correct mode. Transition TURN_UP (`ST_DOWN` to `ST_UP`) fires when the count reaches 0. Transition FORCE_UP sends any state back to `ST_UP` when the mode is not phase-correct. In the PWM modes the compare registers are double-buffered and reload when the count equals TOP. In the other modes the compare inputs take effect at once.

The waveform-mode encodings are 000, 100 and 110 for normal; 010 for CTC; 011 for fast PWM with TOP = 0xFF; 111 for fast PWM with TOP = compare A; 001 for phase-correct with TOP = 0xFF; and 101 for phase-correct with TOP = compare A. Output-mode codes: 00 = off, 01 = toggle, 10 = clear, 11 = set (in the PWM modes 10 and 11 are the non-inverting and inverting forms).

Top module: `wavegen_timer`

## Requirements
- R1: During and just after reset, both pins are 0, the counter is 0 and the direction state is `ST_UP`. Both effective compare buffers are 0.
- R2: In normal mode (waveform mode 000) the counter steps by 1 every clock and wraps from 0xFF to 0. The overflow strobe is high in the cycle the count is 0xFF, so overflow repeats every 256 cycles.
- R3: In CTC mode (010) TOP is compare A. The counter goes to 0 on the clock after it equals TOP, so the period is compare A + 1 cycles. The overflow strobe is high only when the count is 0xFF.
- R4: In fast PWM (011: TOP = 0xFF; 111: TOP = effective compare A) the counter wraps to 0 after TOP. The overflow strobe is high in the cycle the count equals TOP.
- R5: In phase-correct PWM (001: TOP = 0xFF; 101: TOP = effective compare A) the counter runs 0..TOP..0 without repeating either endpoint, so the period is 2*TOP cycles. The overflow strobe is high when the count is 0 while counting down.
- R6: Output code 00 disconnects the channel in every mode. Its override flag is 0 and its pin holds its value.
- R7: In normal and CTC modes, on a match (count equals the channel's compare value) codes 01, 10 and 11 toggle, clear and set the pin on the following clock.
- R8: In fast PWM, code 10 sets the pin at TOP and clears it on a match. Code 11 clears the pin at TOP and sets it on a match.
- R9: In both PWM modes, code 01 toggles channel A on a match only when waveform-mode bit 2 is 1. Otherwise channel A is disconnected. For channel B, code 01 is always disconnected (override 0, pin held).
- R10: In phase-correct PWM, code 10 clears the pin on a match while counting up and sets it on a match while counting down. Code 11 does the reverse.
- R11: In a PWM mode with code 10 or 11, when the compare value equals TOP the match action is skipped. At TOP, code 10 sets the pin and code 11 clears it.
- R12: The override flag is 1 only when the channel is connected and its direction-enable input is 1.
- R13: In PWM modes the effective compare values load from the inputs only in the cycle the count equals TOP. In normal and CTC modes they follow the inputs with no delay. Match strobes compare the count against the effective values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wgm | input | 3 | Waveform mode field |
| com_a | input | 2 | Output mode, channel A |
| com_b | input | 2 | Output mode, channel B |
| cmp_a | input | 8 | Compare value A (also TOP source) |
| cmp_b | input | 8 | Compare value B |
| dir_en_a | input | 1 | Output driver enable, channel A |
| dir_en_b | input | 1 | Output driver enable, channel B |
| pin_a | output | 1 | Waveform value, channel A |
| pin_b | output | 1 | Waveform value, channel B |
| ovr_a | output | 1 | Channel A overrides port data |
| ovr_b | output | 1 | Channel B overrides port data |
| ovf | output | 1 | Overflow strobe |
| match_a | output | 1 | Count equals effective compare A |
| match_b | output | 1 | Count equals effective compare B |

## Verification
The bench builds the block with its default width of 8. At that width a TOP of 0xFF gives full 256-cycle normal and fast periods and 510-cycle phase-correct periods, all inside one 600-cycle run per vector. Vectors that take TOP from compare A use small TOP values, so both counting endpoints, the compare-equals-TOP case and the reload of the compare buffers recur many times in each run. A change to compare B partway through every run exercises the buffering against a model kept in the bench.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } cnt_mode_t;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } dir_state_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } pin_act_t;

    localparam logic [1:0] COM_OFF = 2'b00;
    localparam logic [1:0] COM_TGL = 2'b01;
    localparam logic [1:0] COM_CLR = 2'b10;
    localparam logic [1:0] COM_SET = 2'b11;

endpackage

// File: rtl/wgt_mode_decode.sv
module wgt_mode_decode
    import wgt_pkg::*;
(
    input  logic [2:0] wgm,
    output cnt_mode_t  mode,
    output logic       top_from_a,
    output logic       pwm
);

    always_comb begin
        unique case (wgm)
            3'b001, 3'b101: mode = MODE_PHASE;
            3'b011, 3'b111: mode = MODE_FAST;
            3'b010:         mode = MODE_CTC;
            default:        mode = MODE_NORMAL;
        endcase
    end

    always_comb begin
        pwm        = (mode == MODE_FAST) || (mode == MODE_PHASE);
        top_from_a = (mode == MODE_CTC) || (pwm && wgm[2]);
    end

endmodule

// File: rtl/wgt_counter.sv
module wgt_counter
    import wgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_mode_t    mode,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         count_up,
    output logic         ovf
);

    localparam logic [W-1:0] MAX_CNT = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    dir_state_t   state, nxt_state;
    logic [W-1:0] nxt_cnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UP;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Next state and next count
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        if (mode != MODE_PHASE) begin
            nxt_state = ST_UP;                       // FORCE_UP
            nxt_cnt   = (cnt == top || cnt == MAX_CNT) ? '0 : cnt + ONE;
        end else begin
            unique case (state)
                ST_UP: begin
                    if (top == '0) begin
                        nxt_cnt = '0;
                    end else if (cnt >= top) begin
                        nxt_cnt   = cnt - ONE;
                        nxt_state = ST_DOWN;         // TURN_DOWN
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
                ST_DOWN: begin
                    if (cnt == '0) begin
                        nxt_state = ST_UP;           // TURN_UP
                        nxt_cnt   = (top == '0) ? '0 : ONE;
                    end else begin
                        nxt_cnt = cnt - ONE;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        count_up = (state == ST_UP);
        unique case (mode)
            MODE_NORMAL, MODE_CTC: ovf = (cnt == MAX_CNT);
            MODE_FAST:             ovf = (cnt == top);
            MODE_PHASE:            ovf = (state == ST_DOWN) && (cnt == '0);
        endcase
    end

    AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && ovf) |=> (cnt == '0)); // R2
    AST_CTC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTC && cnt == top) |=> (cnt == '0)); // R3
    AST_FAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAST && cnt == top) |=> (cnt == '0)); // R4
    AST_PHASE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && count_up && top != '0 && cnt >= top) |=> !count_up); // R5

endmodule

// File: rtl/wgt_cmp_buffer.sv
module wgt_cmp_buffer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm,
    input  logic         load,
    input  logic [W-1:0] cmp_in,
    output logic [W-1:0] cmp_eff
);

    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (!pwm || load) begin
            held <= cmp_in;
        end
    end

    always_comb begin
        cmp_eff = pwm ? held : cmp_in;
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load) |=> $stable(held)); // R13

endmodule

// File: rtl/wgt_channel.sv
module wgt_channel
    import wgt_pkg::*;
#(
    parameter int W    = 8,
    parameter bit IS_A = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_mode_t    mode,
    input  logic         wgm_hi,
    input  logic [1:0]   com,
    input  logic         dir_en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    input  logic [W-1:0] top,
    input  logic         count_up,
    output logic         pin,
    output logic         ovr,
    output logic         match_o
);

    logic     match, at_top, pwm, connected, ocr_top;
    pin_act_t act;

    always_comb begin
        match     = (cnt == ocr);
        at_top    = (cnt == top);
        ocr_top   = (ocr == top);
        pwm       = (mode == MODE_FAST) || (mode == MODE_PHASE);
        connected = (com != COM_OFF) && !(pwm && com == COM_TGL && !(IS_A && wgm_hi));
        act       = ACT_HOLD;
        if (com != COM_OFF) begin
            unique case (mode)
                MODE_NORMAL, MODE_CTC: begin
                    if (match) begin
                        unique case (com)
                            COM_TGL: act = ACT_TGL;
                            COM_CLR: act = ACT_CLR;
                            default: act = ACT_SET;
                        endcase
                    end
                end
                MODE_FAST: begin
                    if (com == COM_TGL) begin
                        if (connected && match) act = ACT_TGL;
                    end else if (at_top) begin
                        act = (com == COM_CLR) ? ACT_SET : ACT_CLR;
                    end else if (match) begin
                        act = (com == COM_CLR) ? ACT_CLR : ACT_SET;
                    end
                end
                MODE_PHASE: begin
                    if (com == COM_TGL) begin
                        if (connected && match) act = ACT_TGL;
                    end else if (match && ocr_top) begin
                        act = (com == COM_CLR) ? ACT_SET : ACT_CLR;
                    end else if (match) begin
                        if (count_up) act = (com == COM_CLR) ? ACT_CLR : ACT_SET;
                        else          act = (com == COM_CLR) ? ACT_SET : ACT_CLR;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            unique case (act)
                ACT_HOLD: pin <= pin;
                ACT_SET:  pin <= 1'b1;
                ACT_CLR:  pin <= 1'b0;
                ACT_TGL:  pin <= ~pin;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ovr     = connected && dir_en;
        match_o = match;
    end

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (com == COM_OFF) |=> $stable(pin)); // R6
    AST_FAST_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAST && com == COM_CLR && at_top) |=> pin); // R8
    AST_EQ_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && com == COM_CLR && match && ocr_top) |=> pin); // R11
    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_en) |-> !ovr); // R12

endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
    import wgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   wgm,
    input  logic [1:0]   com_a,
    input  logic [1:0]   com_b,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         dir_en_a,
    input  logic         dir_en_b,
    output logic         pin_a,
    output logic         pin_b,
    output logic         ovr_a,
    output logic         ovr_b,
    output logic         ovf,
    output logic         match_a,
    output logic         match_b
);

    localparam int           NUM_CH  = 2;
    localparam logic [W-1:0] MAX_CNT = {W{1'b1}};

    cnt_mode_t    mode;
    logic         top_from_a, pwm, count_up, load;
    logic [W-1:0] cnt, top;

    logic [1:0]   com_v    [NUM_CH];
    logic [W-1:0] cmp_v    [NUM_CH];
    logic [W-1:0] eff_v    [NUM_CH];
    logic         dir_v    [NUM_CH];
    logic         pin_v    [NUM_CH];
    logic         ovr_v    [NUM_CH];
    logic         match_v  [NUM_CH];

    always_comb begin
        com_v[0] = com_a;    com_v[1] = com_b;
        cmp_v[0] = cmp_a;    cmp_v[1] = cmp_b;
        dir_v[0] = dir_en_a; dir_v[1] = dir_en_b;
        top      = top_from_a ? eff_v[0] : MAX_CNT;
        load     = (cnt == top);
    end

    wgt_mode_decode u_decode (
        .wgm        (wgm),
        .mode       (mode),
        .top_from_a (top_from_a),
        .pwm        (pwm)
    );

    wgt_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .top      (top),
        .cnt      (cnt),
        .count_up (count_up),
        .ovf      (ovf)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        wgt_cmp_buffer #(.W(W)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwm     (pwm),
            .load    (load),
            .cmp_in  (cmp_v[g]),
            .cmp_eff (eff_v[g])
        );

        wgt_channel #(.W(W), .IS_A(g == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .wgm_hi   (wgm[2]),
            .com      (com_v[g]),
            .dir_en   (dir_v[g]),
            .cnt      (cnt),
            .ocr      (eff_v[g]),
            .top      (top),
            .count_up (count_up),
            .pin      (pin_v[g]),
            .ovr      (ovr_v[g]),
            .match_o  (match_v[g])
        );
    end

    always_comb begin
        pin_a   = pin_v[0];   pin_b   = pin_v[1];
        ovr_a   = ovr_v[0];   ovr_b   = ovr_v[1];
        match_a = match_v[0]; match_b = match_v[1];
    end

endmodule

// File: tb/test_wavegen_timer.sv
module test_wavegen_timer;

    localparam int CLK_PERIOD = 10;
    localparam int RUN        = 600;
    localparam int NVEC       = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wgm = '0;
    logic [1:0] com_a = '0, com_b = '0;
    logic [7:0] cmp_a = '0, cmp_b = '0;
    logic       dir_en_a = 1'b0, dir_en_b = 1'b0;
    logic       pin_a, pin_b, ovr_a, ovr_b, ovf, match_a, match_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    wavegen_timer i_wavegen_timer (
        .clk(clk), .rst_n(rst_n), .wgm(wgm), .com_a(com_a), .com_b(com_b),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .dir_en_a(dir_en_a), .dir_en_b(dir_en_b),
        .pin_a(pin_a), .pin_b(pin_b), .ovr_a(ovr_a), .ovr_b(ovr_b),
        .ovf(ovf), .match_a(match_a), .match_b(match_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [2:0] wgm;
        logic [1:0] ca;
        logic [1:0] cb;
        logic [7:0] oa;
        logic [7:0] ob;
        logic       da;
        logic       db;
    } vec_t;

    localparam logic [24:0] VECS [NVEC] = '{
        {3'b000, 2'b01, 2'b10, 8'h20, 8'h40, 1'b1, 1'b1},
        {3'b000, 2'b10, 2'b11, 8'h90, 8'hC0, 1'b1, 1'b1},
        {3'b010, 2'b01, 2'b01, 8'h09, 8'h03, 1'b1, 1'b1},
        {3'b010, 2'b11, 2'b10, 8'h0C, 8'h05, 1'b1, 1'b1},
        {3'b011, 2'b10, 2'b11, 8'h80, 8'h30, 1'b1, 1'b1},
        {3'b111, 2'b11, 2'b10, 8'h0A, 8'h04, 1'b1, 1'b1},
        {3'b011, 2'b01, 2'b01, 8'h40, 8'h20, 1'b1, 1'b1},
        {3'b111, 2'b01, 2'b01, 8'h07, 8'h03, 1'b1, 1'b1},
        {3'b001, 2'b10, 2'b11, 8'h40, 8'hC0, 1'b1, 1'b1},
        {3'b101, 2'b01, 2'b10, 8'h07, 8'h03, 1'b1, 1'b1},
        {3'b101, 2'b10, 2'b11, 8'h06, 8'h06, 1'b1, 1'b1},
        {3'b001, 2'b11, 2'b10, 8'h00, 8'hFF, 1'b1, 1'b1},
        {3'b011, 2'b00, 2'b10, 8'h50, 8'hFF, 1'b1, 1'b1},
        {3'b000, 2'b01, 2'b00, 8'h20, 8'h30, 1'b0, 1'b1}
    };

    localparam string TAGS [NVEC] = '{
        "R2 R7", "R7", "R3 R7", "R3 R7", "R4 R8", "R4 R8 R11", "R9",
        "R9", "R5 R10 R13", "R5 R9 R10", "R11", "R10 R11", "R6 R11", "R6 R12"
    };

    // Bench model state
    logic [7:0] m_cnt, m_bufa, m_bufb;
    bit         m_down;
    logic       m_pa, m_pb;

    task automatic check(input string req, input string what,
                         input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b exp %b", req, what, got, exp);
        end
    endtask

    function automatic int mode_of(input logic [2:0] w);
        case (w)
            3'b001, 3'b101: return 3;
            3'b011, 3'b111: return 2;
            3'b010:         return 1;
            default:        return 0;
        endcase
    endfunction

    function automatic bit conn(input logic [1:0] c, input bit is_a, input int m, input bit hi);
        if (c == 2'b00) return 0;
        if (m >= 2 && c == 2'b01 && !(is_a && hi)) return 0;
        return 1;
    endfunction

    function automatic logic next_pin(input logic p, input logic [1:0] c, input bit is_a,
                                      input int m, input bit hi, input bit mt,
                                      input bit attop, input bit eqtop, input bit up);
        if (c == 2'b00) return p;
        if (m < 2) begin
            if (!mt) return p;
            if (c == 2'b01) return ~p;
            return (c == 2'b11);
        end
        if (c == 2'b01) return (is_a && hi && mt) ? ~p : p;
        if (m == 2) begin
            if (attop) return (c == 2'b10);
            if (mt)    return (c == 2'b11);
            return p;
        end
        if (mt && eqtop) return (c == 2'b10);
        if (mt) return up ? (c == 2'b11) : (c == 2'b10);
        return p;
    endfunction

    // Compare outputs against the model, then advance the model by one clock
    task automatic model_step(input string req, input int k);
        int m; bit pwm, tfa, hi;
        logic [7:0] ea, eb, top;
        logic [6:0] exp, got;
        bit ex_ovf;
        m   = mode_of(wgm);
        pwm = (m >= 2);
        hi  = wgm[2];
        tfa = (m == 1) || (pwm && hi);
        ea  = pwm ? m_bufa : cmp_a;
        eb  = pwm ? m_bufb : cmp_b;
        top = tfa ? ea : 8'hFF;
        case (m)
            0, 1:    ex_ovf = (m_cnt == 8'hFF);
            2:       ex_ovf = (m_cnt == top);
            default: ex_ovf = m_down && (m_cnt == 8'h00);
        endcase
        exp = {m_pa, m_pb, conn(com_a, 1, m, hi) && dir_en_a, conn(com_b, 0, m, hi) && dir_en_b,
               ex_ovf, (m_cnt == ea), (m_cnt == eb)};
        got = {pin_a, pin_b, ovr_a, ovr_b, ovf, match_a, match_b};
        check(req, $sformatf("cycle %0d pins/ovr/ovf/match", k), got, exp);
        m_pa = next_pin(m_pa, com_a, 1, m, hi, m_cnt == ea, m_cnt == top, ea == top, !m_down);
        m_pb = next_pin(m_pb, com_b, 0, m, hi, m_cnt == eb, m_cnt == top, eb == top, !m_down);
        if (!pwm || m_cnt == top) begin
            m_bufa = cmp_a;
            m_bufb = cmp_b;
        end
        if (m != 3) begin
            m_down = 0;
            m_cnt  = (m_cnt == top || m_cnt == 8'hFF) ? 8'h00 : m_cnt + 8'h01;
        end else if (!m_down) begin
            if (top == 8'h00) m_cnt = 8'h00;
            else if (m_cnt >= top) begin m_cnt = m_cnt - 8'h01; m_down = 1; end
            else m_cnt = m_cnt + 8'h01;
        end else begin
            if (m_cnt == 8'h00) begin m_down = 0; m_cnt = (top == 8'h00) ? 8'h00 : 8'h01; end
            else m_cnt = m_cnt - 8'h01;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/2 + 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_cnt = 8'h00; m_bufa = 8'h00; m_bufb = 8'h00; m_down = 0; m_pa = 0; m_pb = 0;
        @(posedge clk);
        @(posedge clk);
        #(CLK_PERIOD/2 + 1);
        check("R1", "pins in reset", {5'b0, pin_a, pin_b}, 7'b0);
        rst_n = 1'b1;
        #1;
    endtask

    function automatic logic probe(input int which);
        case (which)
            0:       return ovf;
            1:       return match_a;
            2:       return match_b;
            default: return pin_b;
        endcase
    endfunction

    task automatic gap(input int which, output int g);
        int first;
        first = -1;
        g = -1;
        for (int k = 0; k < 700; k++) begin
            if (probe(which)) begin
                if (first < 0) first = k;
                else begin g = k - first; break; end
            end
            tick();
        end
    endtask

    task automatic setup(input logic [2:0] w, input logic [1:0] ca, input logic [1:0] cb,
                         input logic [7:0] oa, input logic [7:0] ob);
        wgm = w; com_a = ca; com_b = cb; cmp_a = oa; cmp_b = ob;
        dir_en_a = 1'b1; dir_en_b = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t cv;
        int   g;
        logic all_hi;

        // Vector table walked by one loop
        for (int v = 0; v < NVEC; v++) begin
            cv = vec_t'(VECS[v]);
            wgm = cv.wgm; com_a = cv.ca; com_b = cv.cb;
            cmp_a = cv.oa; cmp_b = cv.ob; dir_en_a = cv.da; dir_en_b = cv.db;
            do_reset();
            for (int k = 0; k < RUN; k++) begin
                if (k == 300) begin
                    cmp_b = cv.ob ^ 8'h03;   // R13 mid-run change
                    #1;
                end
                model_step(TAGS[v], k);
                tick();
            end
        end

        // R1: reset state with pins previously high
        setup(3'b000, 2'b11, 2'b11, 8'h05, 8'h00);
        do_reset();
        check("R1", "match_a after reset (count 0, cmp 5)", {6'b0, match_a}, 7'b0);
        check("R1", "match_b after reset (count 0, cmp 0)", {6'b0, match_b}, 7'b1);

        // R2: normal overflow period
        setup(3'b000, 2'b00, 2'b00, 8'h00, 8'h00);
        do_reset();
        gap(0, g);
        check("R2", "normal overflow period", 7'(g), 7'(256 % 128));
        check("R2", "normal overflow period hi", 7'(g / 128), 7'd2);

        // R3: CTC period compare A + 1
        setup(3'b010, 2'b01, 2'b00, 8'h04, 8'h00);
        do_reset();
        gap(1, g);
        check("R3", "CTC match period", 7'(g), 7'd5);

        // R4: fast PWM, TOP from A
        setup(3'b111, 2'b00, 2'b00, 8'h09, 8'h00);
        do_reset();
        gap(0, g);
        check("R4", "fast overflow period", 7'(g), 7'd10);

        // R5: phase-correct period 2*TOP
        setup(3'b101, 2'b00, 2'b00, 8'h06, 8'h00);
        do_reset();
        gap(0, g);
        check("R5", "phase overflow period", 7'(g), 7'd12);

        // R11: compare B equals TOP in phase-correct, code 10 -> constant high
        setup(3'b101, 2'b00, 2'b10, 8'h06, 8'h06);
        do_reset();
        all_hi = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (k >= 10 && !pin_b) all_hi = 1'b0;
            tick();
        end
        check("R11", "pin_b held high", {6'b0, all_hi}, 7'b1);

        // R12: direction enable gates override
        setup(3'b000, 2'b01, 2'b00, 8'h10, 8'h00);
        dir_en_a = 1'b0;
        #1;
        check("R12", "ovr_a with enable 0", {6'b0, ovr_a}, 7'b0);
        dir_en_a = 1'b1;
        #1;
        check("R12", "ovr_a with enable 1", {6'b0, ovr_a}, 7'b1);

        // R9: code 01 in fast PWM
        setup(3'b011, 2'b01, 2'b01, 8'h10, 8'h10);
        #1;
        check("R9", "fast 011 code 01 overrides", {5'b0, ovr_a, ovr_b}, 7'b0);
        setup(3'b111, 2'b01, 2'b01, 8'h10, 8'h10);
        #1;
        check("R9", "fast 111 code 01 overrides", {5'b0, ovr_a, ovr_b}, 7'b10);

        // R13: buffered compare B in fast PWM (TOP 20)
        setup(3'b111, 2'b00, 2'b00, 8'd20, 8'd5);
        do_reset();
        for (int k = 0; k < 40; k++) begin
            if (k == 2) begin cmp_b = 8'd15; #1; end
            if (k == 6)  check("R13", "fast old compare match at k6", {6'b0, match_b}, 7'b1);
            if (k == 16) check("R13", "fast new compare not yet at k16", {6'b0, match_b}, 7'b0);
            if (k == 37) check("R13", "fast new compare after TOP at k37", {6'b0, match_b}, 7'b1);
            tick();
        end
        // R13: immediate compare B in normal mode
        setup(3'b000, 2'b00, 2'b00, 8'd20, 8'd5);
        do_reset();
        for (int k = 0; k < 20; k++) begin
            if (k == 2) begin cmp_b = 8'd15; #1; end
            if (k == 15) check("R13", "normal new compare at k15", {6'b0, match_b}, 7'b1);
            tick();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule